// File: doc/BRIEF.md
# Base-Limit Address Guard

This block sits between a processor's address output and its memory port. It holds two registers, a window start (base) and a window length (limit), and checks every user-mode request against them. If a user address falls inside the window, the block grants the access and issues a relocated physical address: the logical address plus the base. If the address falls outside the window, the block raises a trap and drives no address toward memory. Kernel-mode requests skip the check and pass through unchanged.

Only kernel-mode software may load the base and limit registers. It does so through a small configuration port, with a select bit that picks the register and a mode bit that gives the requester's privilege. A write attempted from user mode changes nothing. Instead it raises a one-cycle privilege-error pulse. Every response is registered and appears exactly one cycle after the request.

Top module: `bl_guard`

## Requirements
- R1: After reset both registers hold zero and all outputs are low, so every user-mode request traps until the registers are loaded.
- R2: A user-mode request is legal exactly when base <= addr and addr < base + limit. The sum is formed with one extra carry bit, so it never wraps.
- R3: A legal user-mode request is granted with rsp_phys = addr + base, formed as an ADDR_W+1 bit sum.
- R4: An illegal user-mode request gives rsp_trap = 1, rsp_grant = 0 and rsp_phys = 0.
- R5: A kernel-mode request (req_kernel = 1) is always granted with rsp_phys equal to addr zero-extended, whatever the base and limit hold.
- R6: For a request presented at a clock edge, grant or trap is asserted in the cycle after that edge and in no other. With no request both stay low.
- R7: A write with cfg_kernel = 1 loads the base when cfg_sel = 0 and the limit when cfg_sel = 1. The new value applies from the next request onward. A request presented in the same cycle as the write still sees the old value.
- R8: A write with cfg_kernel = 0 leaves both registers unchanged. This can be seen on later requests.
- R9: A rejected user-mode write sets cfg_priv_err high for exactly the one cycle after the write. Otherwise cfg_priv_err stays low.
- R10: The top of the window is inclusive at base + limit - 1 and exclusive at base + limit. This holds even when base + limit exceeds 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_kernel | input | 1 | Privilege of the writer: 1 is kernel |
| cfg_sel | input | 1 | 0 selects the base, 1 selects the limit |
| cfg_wdata | input | ADDR_W | Value to load |
| cfg_priv_err | output | 1 | One-cycle pulse after a rejected user write |
| req_valid | input | 1 | Request present |
| req_kernel | input | 1 | Privilege of the request: 1 is kernel |
| req_addr | input | ADDR_W | Logical address |
| rsp_grant | output | 1 | Access allowed |
| rsp_trap | output | 1 | Access refused |
| rsp_phys | output | ADDR_W+1 | Physical address, zero unless granted |

## Verification
A corrupted base or limit shows up on the first user request after the corruption. Such a request either traps when it should be granted, or it carries a relocated address that is off by the error, and both appear one cycle after the request. A wrong privilege gate shows in two places: in the pulse on cfg_priv_err one cycle after the write, and on the next request that depends on the register that should have stayed put. The bench aims requests at base - 1, base, base + limit - 1 and base + limit, and at windows that carry past 2^ADDR_W. This makes an off-by-one compare or a dropped carry bit show up on the very next response.

// File: rtl/bl_pkg.sv
package bl_pkg;

    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } bl_sel_e;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_GRANT = 2'd1,
        RSP_TRAP  = 2'd2
    } bl_rsp_e;

    function automatic bl_rsp_e bl_classify(input logic valid, input logic legal);
        if (!valid)     return RSP_NONE;
        else if (legal) return RSP_GRANT;
        else            return RSP_TRAP;
    endfunction

endpackage

// File: rtl/bl_bound_regs.sv
module bl_bound_regs
    import bl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_kernel,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] limit_q,
    output logic              priv_err
);

    bl_sel_e sel;
    logic    allowed;
    logic    rejected;

    assign sel      = bl_sel_e'(wr_sel);
    assign allowed  = wr_en &&  wr_kernel;
    assign rejected = wr_en && !wr_kernel;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            limit_q  <= '0;
            priv_err <= 1'b0;
        end else begin
            priv_err <= rejected;
            if (allowed) begin
                if (sel == SEL_BASE) base_q  <= wr_data;
                else                 limit_q <= wr_data;
            end
        end
    end

    // R8
    a_r8_user_write_ignored: assert property (@(posedge clk) disable iff (rst)
        rejected |=> ($stable(base_q) && $stable(limit_q)));

    // R9
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
        rejected |=> priv_err);
    a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
        !rejected |=> !priv_err);

endmodule

// File: rtl/bl_range_check.sv
module bl_range_check #(
    parameter int ADDR_W = 32
) (
    input  logic              kernel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    output logic              legal,
    output logic [ADDR_W:0]   phys
);

    localparam int WIDE = ADDR_W + 1;

    logic [WIDE-1:0] addr_w;
    logic [WIDE-1:0] base_w;
    logic [WIDE-1:0] top_w;
    logic            above_lo;
    logic            below_hi;

    assign addr_w   = {1'b0, addr};
    assign base_w   = {1'b0, base};
    assign top_w    = base_w + {1'b0, limit};
    assign above_lo = addr_w >= base_w;
    assign below_hi = addr_w <  top_w;

    always_comb begin
        if (kernel) begin
            legal = 1'b1;
            phys  = addr_w;
        end else begin
            legal = above_lo && below_hi;
            phys  = addr_w + base_w;
        end
    end

endmodule

// File: rtl/bl_resp_stage.sv
module bl_resp_stage
    import bl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid,
    input  logic            legal,
    input  logic [ADDR_W:0] phys_in,
    output logic            grant,
    output logic            trap,
    output logic [ADDR_W:0] phys_out
);

    bl_rsp_e kind_q;
    bl_rsp_e kind_d;

    assign kind_d = bl_classify(valid, legal);

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q   <= RSP_NONE;
            phys_out <= '0;
        end else begin
            kind_q   <= kind_d;
            phys_out <= (kind_d == RSP_GRANT) ? phys_in : '0;
        end
    end

    assign grant = (kind_q == RSP_GRANT);
    assign trap  = (kind_q == RSP_TRAP);

    // R4
    a_r4_trap_no_addr: assert property (@(posedge clk) disable iff (rst)
        trap |-> (phys_out == '0));

endmodule

// File: rtl/bl_guard.sv
module bl_guard #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic              cfg_kernel,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              cfg_priv_err,
    input  logic              req_valid,
    input  logic              req_kernel,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_grant,
    output logic              rsp_trap,
    output logic [ADDR_W:0]   rsp_phys
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] limit_q;
    logic              legal;
    logic [ADDR_W:0]   phys_c;

    bl_bound_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_wr_en),
        .wr_kernel (cfg_kernel),
        .wr_sel    (cfg_sel),
        .wr_data   (cfg_wdata),
        .base_q    (base_q),
        .limit_q   (limit_q),
        .priv_err  (cfg_priv_err)
    );

    bl_range_check #(.ADDR_W(ADDR_W)) u_check (
        .kernel (req_kernel),
        .addr   (req_addr),
        .base   (base_q),
        .limit  (limit_q),
        .legal  (legal),
        .phys   (phys_c)
    );

    bl_resp_stage #(.ADDR_W(ADDR_W)) u_resp (
        .clk      (clk),
        .rst      (rst),
        .valid    (req_valid),
        .legal    (legal),
        .phys_in  (phys_c),
        .grant    (rsp_grant),
        .trap     (rsp_trap),
        .phys_out (rsp_phys)
    );

    // R6
    a_r6_one_cycle_resp: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_grant ^ rsp_trap));
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_grant && !rsp_trap));

    // R5
    a_r5_kernel_grant: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kernel) |=> (rsp_grant && rsp_phys == {1'b0, $past(req_addr)}));

    // R4
    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rsp_grant && rsp_trap));

endmodule

// File: tb/test_bl_guard.sv
module test_bl_guard;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_wr_en, cfg_kernel, cfg_sel;
    logic [AW-1:0] cfg_wdata;
    logic          cfg_priv_err;
    logic          req_valid, req_kernel;
    logic [AW-1:0] req_addr;
    logic          rsp_grant, rsp_trap;
    logic [AW:0]   rsp_phys;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [AW-1:0] m_base  = '0;
    logic [AW-1:0] m_limit = '0;

    always #2.5 clk = ~clk;

    bl_guard #(.ADDR_W(AW)) i_bl_guard (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_kernel(cfg_kernel), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_priv_err(cfg_priv_err),
        .req_valid(req_valid), .req_kernel(req_kernel), .req_addr(req_addr),
        .rsp_grant(rsp_grant), .rsp_trap(rsp_trap), .rsp_phys(rsp_phys)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit f_legal(input bit kern, input logic [AW-1:0] a,
                                   input logic [AW-1:0] b, input logic [AW-1:0] l);
        logic [AW:0] top;
        top = {1'b0, b} + {1'b0, l};
        return kern || (({1'b0, a} >= {1'b0, b}) && ({1'b0, a} < top));
    endfunction

    function automatic logic [AW:0] f_phys(input bit kern, input logic [AW-1:0] a,
                                           input logic [AW-1:0] b, input logic [AW-1:0] l);
        if (!f_legal(kern, a, b, l)) return '0;
        if (kern) return {1'b0, a};
        return {1'b0, a} + {1'b0, b};
    endfunction

    task automatic idle_inputs();
        cfg_wr_en = 0; cfg_kernel = 0; cfg_sel = 0; cfg_wdata = '0;
        req_valid = 0; req_kernel = 0; req_addr = '0;
    endtask

    task automatic check_resp(input bit kern, input logic [AW-1:0] a, input string tag);
        bit          eg;
        logic [AW:0] ep;
        eg = f_legal(kern, a, m_base, m_limit);
        ep = f_phys(kern, a, m_base, m_limit);
        chk(rsp_grant == eg, {tag, " grant"}, 64'(rsp_grant), 64'(eg));
        chk(rsp_trap == !eg, {tag, " trap"},  64'(rsp_trap),  64'(!eg));
        chk(rsp_phys == ep,  {tag, " phys"},  64'(rsp_phys),  64'(ep));
    endtask

    // request at the next edge; check after that edge
    task automatic do_req(input bit kern, input logic [AW-1:0] a, input string tag);
        req_valid = 1; req_kernel = kern; req_addr = a;
        @(negedge clk);
        idle_inputs();
        check_resp(kern, a, tag);
    endtask

    task automatic do_wr(input bit kern, input bit sel, input logic [AW-1:0] d);
        cfg_wr_en = 1; cfg_kernel = kern; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        idle_inputs();
        chk(cfg_priv_err == !kern, "R9 priv_err after write", 64'(cfg_priv_err), 64'(!kern));
        if (kern) begin
            if (sel) m_limit = d; else m_base = d;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!rsp_grant && !rsp_trap && rsp_phys == '0, "R1 outputs after reset",
            64'({rsp_grant, rsp_trap}), 64'd0);
        chk(!cfg_priv_err, "R1 priv_err after reset", 64'(cfg_priv_err), 64'd0);
        do_req(0, 32'd0, "R1 user access traps at reset");
        do_req(0, 32'd1000, "R1 user access traps at reset");

        // R7 kernel load, R2/R3/R10 window edges
        do_wr(1, 0, 32'd300040);
        do_wr(1, 1, 32'd120900);
        do_req(0, 32'd300040, "R3 relocate at base");
        do_req(0, 32'd420939, "R10 last legal address");
        do_req(0, 32'd420940, "R10 first illegal address");
        do_req(0, 32'd300039, "R2 below base");
        do_req(1, 32'd5, "R5 kernel bypass");
        // R6 idle cycle
        @(negedge clk);
        chk(!rsp_grant && !rsp_trap, "R6 idle quiet", 64'({rsp_grant, rsp_trap}), 64'd0);

        // R8 user write ignored, R9 pulse width
        do_wr(0, 0, 32'd0);
        @(negedge clk);
        chk(!cfg_priv_err, "R9 pulse lasts one cycle", 64'(cfg_priv_err), 64'd0);
        do_wr(0, 1, 32'hFFFF_FFFF);
        do_req(0, 32'd300040, "R8 base unchanged after user write");
        do_req(0, 32'd420940, "R8 limit unchanged after user write");

        // R3 relocation example
        do_wr(1, 0, 32'd14000);
        do_wr(1, 1, 32'd1000);
        do_req(0, 32'd14346, "R3 relocate");

        // R7 same-cycle write and request sees old value
        cfg_wr_en = 1; cfg_kernel = 1; cfg_sel = 1; cfg_wdata = 32'd10;
        req_valid = 1; req_kernel = 0; req_addr = 32'd14500;
        @(negedge clk);
        idle_inputs();
        check_resp(0, 32'd14500, "R7 same-cycle uses old limit");
        m_limit = 32'd10;
        do_req(0, 32'd14500, "R7 new limit applies next");

        // R10 window across 2^AW
        do_wr(1, 0, 32'hFFFF_FFF0);
        do_wr(1, 1, 32'h0000_0020);
        do_req(0, 32'hFFFF_FFFF, "R10 carry window top");
        do_req(0, 32'hFFFF_FFF0, "R10 carry window base");
        do_req(0, 32'd3, "R10 no wrap below base");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int unsigned pick;
            logic [AW-1:0] a;
            pick = $urandom % 16;
            if (pick == 0) begin
                do_wr(1, $urandom % 2 == 1, (($urandom % 4) == 0) ? $urandom : ($urandom % 32'h0010_0000));
            end else if (pick == 1) begin
                do_wr(0, $urandom % 2 == 1, $urandom);
            end else if (pick == 2) begin
                @(negedge clk);
                chk(!rsp_grant && !rsp_trap, "R6 random idle", 64'({rsp_grant, rsp_trap}), 64'd0);
            end else begin
                case ($urandom % 5)
                    0: a = m_base - 1;
                    1: a = m_base;
                    2: a = m_base + m_limit - 1;
                    3: a = m_base + m_limit;
                    default: a = m_base + ($urandom % (m_limit + 2));
                endcase
                if (($urandom % 6) == 0) do_req(1, $urandom, "R5 random kernel");
                else                     do_req(0, a, "R2 random user");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule